// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase Comparator Core

This core holds the digital half of a fixed-step frequency synthesizer. A main counter divides the prescaled RF signal by a programmable ratio: a fixed base of 2176 plus a 7-bit word. A reference counter divides the crystal signal by 4, 8, 12 or 16, chosen by a 2-bit code. The terminal pulses of the two counters drive a phase/frequency comparator. The comparator produces a source request (`pump_up`) and a sink request (`pump_dn`) for an external charge pump. Each request is as wide as the gap between the two counters' terminal pulses.

Both divided signals arrive in one core clock domain as one-cycle tick strobes, and each strobe stands for one input edge. The `enable` input starts and stops the loop. On start, both counters and the comparator leave a common reload state together, so no arbitrary starting phase error appears. On stop, the block keeps running until any pump request in flight has finished. Only then does it return to the held state.

Top module: `fsyn_core`

## Requirements
- R1: The main ratio is 2176 + n, where n = {mdiv_hi, mdiv_lsb}. mdiv_hi[5] is the MSB of n and mdiv_lsb is its LSB, so ratios 2176 to 2303 are reachable. A tick counts on every clock edge at which it is high.
- R2: ref_sel selects the reference ratio: 2'b00 gives 4, 2'b01 gives 16, 2'b10 gives 8 and 2'b11 gives 12.
- R3: If the reference counter reaches its terminal count first, pump_up asserts; if the main counter does, pump_dn asserts. The output rises one clock edge after the edge that registers that counter's ratio-th tick.
- R4: The output that leads stays high for (arrival difference in cycles + OVERLAP) cycles, and the output that lags stays high for OVERLAP cycles. Equal arrival gives both outputs OVERLAP cycles (OVERLAP defaults to 2).
- R5: Once pump_up and pump_dn are both high, they stay high together for exactly OVERLAP cycles and then fall on the same edge.
- R6: The edge that sees enable high moves the block out of idle. Both counters start counting on the following edge from a full reload, so the first terminal count of each comes exactly its ratio in ticks later.
- R7: A low enable never cuts a pump request short. The block returns to idle only when both outputs are low and no counter terminal pulse is pending.
- R8: While idle, pump_up and pump_dn are low, ticks are ignored, and both counters are held at the reload value of the words currently applied.
- R9: A change of mdiv_hi, mdiv_lsb or ref_sel takes effect only at that counter's next terminal count and never shortens or lengthens the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, faster than either tick stream |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Starts (high) and stops (low) the loop |
| main_tick | input | 1 | One-cycle strobe per prescaled RF edge |
| ref_tick | input | 1 | One-cycle strobe per crystal edge |
| mdiv_hi | input | 6 | Upper six bits of n, bit 5 is the MSB |
| mdiv_lsb | input | 1 | Least significant bit of n |
| ref_sel | input | 2 | Reference ratio code |
| pump_up | output | 1 | Source request to the charge pump |
| pump_dn | output | 1 | Sink request to the charge pump |

## Verification
The bench times the first pump edge after each start. An off-by-one reload, or a counter that was not held while idle, moves that edge away from ratio+1. Pulse widths are measured with the reference leading by one and by two cycles, with the main counter leading, and with equal arrival. A swapped bit order in n or a swapped reference code gives the wrong width or the wrong output, and a missing overlap shows up as zero-width equal-arrival pulses. The main word is changed mid-count to catch an immediate reload. Enable is dropped in the middle of a source request to catch truncation, which would cut the request short or leave stray requests while ticks continue.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;

    localparam int REF_MAX = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    // Reference ratio code, deliberately non-monotonic.
    function automatic int ref_ratio(input logic [1:0] code);
        case (code)
            2'b00:   return 4;
            2'b01:   return 16;
            2'b10:   return 8;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/fsyn_divider.sv
module fsyn_divider #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] ratio,
    output logic             pulse
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ratio;
        logic             pulse;
    } div_s;

    div_s div_d, div_q;

    always_comb begin
        div_d       = div_q;
        div_d.pulse = 1'b0;
        if (!run) begin
            // held at reload of the live word
            div_d.cnt   = ratio - ONE;
            div_d.ratio = ratio;
        end else if (tick) begin
            if (div_q.cnt == '0) begin
                div_d.pulse = 1'b1;
                div_d.cnt   = ratio - ONE;
                div_d.ratio = ratio;
            end else begin
                div_d.cnt = div_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign pulse = div_q.pulse;

    // R9: the word in force changes only at a terminal count or while held
    p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(tick && (div_q.cnt == '0))) |-> $stable(div_q.ratio));

    // R1: the count never leaves the range of the ratio in force
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (div_q.ratio != '0)) |-> (div_q.cnt < div_q.ratio));

endmodule

// File: rtl/fsyn_pfd.sv
module fsyn_pfd #(
    parameter int OVERLAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_pulse,
    input  logic main_pulse,
    output logic up,
    output logic dn
);

    localparam int OV_W = $clog2(OVERLAP + 1);
    localparam logic [OV_W-1:0] OV_LAST = OV_W'(OVERLAP - 1);
    localparam logic [OV_W-1:0] OV_ONE  = OV_W'(1);

    typedef struct packed {
        logic            up;
        logic            dn;
        logic [OV_W-1:0] ovl;
    } pfd_s;

    pfd_s pfd_d, pfd_q;

    always_comb begin
        pfd_d = pfd_q;
        if (!run) begin
            pfd_d = '0;
        end else if (pfd_q.up && pfd_q.dn) begin
            if (pfd_q.ovl == OV_LAST) begin
                pfd_d.up  = 1'b0;
                pfd_d.dn  = 1'b0;
                pfd_d.ovl = '0;
            end else begin
                pfd_d.ovl = pfd_q.ovl + OV_ONE;
            end
        end else begin
            if (ref_pulse)  pfd_d.up = 1'b1;
            if (main_pulse) pfd_d.dn = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pfd_q <= '0;
        else        pfd_q <= pfd_d;
    end

    assign up = pfd_q.up;
    assign dn = pfd_q.dn;

    // R5: the two requests always drop on the same edge
    p_up_falls_with_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pfd_q.up) |-> !pfd_q.dn);
    p_dn_falls_with_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pfd_q.dn) |-> !pfd_q.up);

endmodule

// File: rtl/fsyn_core.sv
module fsyn_core #(
    parameter int MAIN_BASE = 2176,
    parameter int N_W       = 7,
    parameter int HI_W      = N_W - 1,
    parameter int SEL_W     = 2,
    parameter int OVERLAP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             main_tick,
    input  logic             ref_tick,
    input  logic [HI_W-1:0]  mdiv_hi,
    input  logic             mdiv_lsb,
    input  logic [SEL_W-1:0] ref_sel,
    output logic             pump_up,
    output logic             pump_dn
);
    import fsyn_pkg::*;

    localparam int MAIN_CW = $clog2(MAIN_BASE + (1 << N_W));
    localparam int REF_CW  = $clog2(REF_MAX + 1);

    logic [N_W-1:0]     n_word;
    logic [MAIN_CW-1:0] main_ratio;
    logic [REF_CW-1:0]  ref_ratio_w;
    logic               run;
    logic               main_pulse;
    logic               ref_pulse;

    assign n_word      = {mdiv_hi, mdiv_lsb};
    assign main_ratio  = MAIN_CW'(MAIN_BASE) + {{(MAIN_CW-N_W){1'b0}}, n_word};
    assign ref_ratio_w = REF_CW'(ref_ratio(ref_sel));

    typedef struct packed {
        seq_state_e state;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_IDLE:  if (enable) seq_d.state = ST_RUN;
            ST_RUN:   if (!enable) seq_d.state = ST_DRAIN;
            ST_DRAIN: if (!pump_up && !pump_dn && !ref_pulse && !main_pulse)
                          seq_d.state = ST_IDLE;
            default:  seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE};
        else        seq_q <= seq_d;
    end

    assign run = (seq_q.state != ST_IDLE);

    fsyn_divider #(.CNT_W(MAIN_CW)) i_main_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (main_tick),
        .ratio (main_ratio),
        .pulse (main_pulse)
    );

    fsyn_divider #(.CNT_W(REF_CW)) i_ref_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (ref_tick),
        .ratio (ref_ratio_w),
        .pulse (ref_pulse)
    );

    fsyn_pfd #(.OVERLAP(OVERLAP)) i_pfd (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .ref_pulse  (ref_pulse),
        .main_pulse (main_pulse),
        .up         (pump_up),
        .dn         (pump_dn)
    );

    // R8: one cycle of idle leaves both requests low
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_q.state == ST_IDLE) |-> (!pump_up && !pump_dn));

    // R7: idle is reached only after the requests have finished
    p_drain_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_q.state == ST_DRAIN) && (seq_q.state == ST_IDLE))
            |-> ($past(!pump_up) && $past(!pump_dn)));

    // R6: a start never begins with a request already pending
    p_clean_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_q.state == ST_IDLE) && (seq_q.state == ST_RUN))
            |-> (!pump_up && !pump_dn && !main_pulse && !ref_pulse));

endmodule

// File: tb/test_fsyn_core.sv
`timescale 1ns/1ps
module test_fsyn_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       main_tick = 1'b0;
    logic       ref_tick = 1'b0;
    logic [5:0] mdiv_hi = '0;
    logic       mdiv_lsb = 1'b0;
    logic [1:0] ref_sel = '0;
    logic       pump_up;
    logic       pump_dn;

    int checks = 0;
    int fails  = 0;
    int first_up, first_dn, up_a, dn_a, up_b, dn_b;

    always #4 clk = ~clk;

    fsyn_core i_fsyn_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .main_tick (main_tick),
        .ref_tick  (ref_tick),
        .mdiv_hi   (mdiv_hi),
        .mdiv_lsb  (mdiv_lsb),
        .ref_sel   (ref_sel),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn)
    );

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Sample s is taken after clock edge s, counting the edge that left idle as edge 0.
    task automatic observe(input int gm, input int gr, input int nsamp, input int split,
                           input int chg_s, input logic [5:0] chg_hi, input logic chg_lsb,
                           input int dis_s);
        first_up = -1; first_dn = -1;
        up_a = 0; dn_a = 0; up_b = 0; dn_b = 0;
        for (int s = 0; s < nsamp; s++) begin
            if (pump_up && first_up < 0) first_up = s;
            if (pump_dn && first_dn < 0) first_dn = s;
            if (s < split) begin
                up_a += int'(pump_up); dn_a += int'(pump_dn);
            end else begin
                up_b += int'(pump_up); dn_b += int'(pump_dn);
            end
            main_tick = ((s % gm) == gm - 1);
            ref_tick  = ((s % gr) == gr - 1);
            if (s == chg_s) begin mdiv_hi = chg_hi; mdiv_lsb = chg_lsb; end
            if (s == dis_s) enable = 1'b0;
            @(posedge clk); @(negedge clk);
        end
        main_tick = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic start_run(input logic [5:0] hi, input logic lsb, input logic [1:0] sel);
        mdiv_hi = hi; mdiv_lsb = lsb; ref_sel = sel;
        main_tick = 1'b0; ref_tick = 1'b0;
        enable = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic go_idle();
        enable = 1'b0; main_tick = 1'b0; ref_tick = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset_idle();
        check(int'(pump_up), 0, "R8 pump_up after reset");
        check(int'(pump_dn), 0, "R8 pump_dn after reset");
        observe(1, 1, 3000, 3000, -1, 6'd0, 1'b0, -1);
        check(up_a, 0, "R8 pump_up cycles while idle with ticks");
        check(dn_a, 0, "R8 pump_dn cycles while idle with ticks");
    endtask

    task automatic t_equal();
        start_run(6'd0, 1'b0, 2'b00);
        observe(1, 544, 2200, 2200, -1, 6'd0, 1'b0, -1);
        check(first_up, 2177, "R6 first pump_up edge ratio 2176/4");
        check(first_dn, 2177, "R6 first pump_dn edge ratio 2176");
        check(up_a, 2, "R5 equal arrival pump_up width");
        check(dn_a, 2, "R5 equal arrival pump_dn width");
        go_idle();
    endtask

    task automatic t_lsb();
        start_run(6'd0, 1'b1, 2'b01);
        observe(1, 136, 2200, 2200, -1, 6'd0, 1'b1, -1);
        check(first_up, 2177, "R2 code 01 ratio 16 pump_up edge");
        check(first_dn, 2178, "R1 lsb gives 2177 pump_dn edge");
        check(up_a, 3, "R4 ref leads by 1 pump_up width");
        check(dn_a, 2, "R4 lag pump_dn width");
        go_idle();
    endtask

    task automatic t_bit_order();
        start_run(6'd1, 1'b0, 2'b10);
        observe(1, 272, 2200, 2200, -1, 6'd1, 1'b0, -1);
        check(first_up, 2177, "R2 code 10 ratio 8 pump_up edge");
        check(first_dn, 2179, "R1 hi bit0 weighs 2");
        check(up_a, 4, "R4 ref leads by 2 pump_up width");
        check(dn_a, 2, "R4 lag pump_dn width");
        go_idle();
    endtask

    task automatic t_main_first();
        start_run(6'd4, 1'b0, 2'b11);
        observe(1, 183, 2300, 2300, -1, 6'd4, 1'b0, -1);
        check(first_dn, 2185, "R3 main first asserts pump_dn");
        check(first_up, 2197, "R2 code 11 ratio 12 pump_up edge");
        check(dn_a, 14, "R4 main leads by 12 pump_dn width");
        check(up_a, 2, "R4 lag pump_up width");
        go_idle();
        start_run(6'd63, 1'b1, 2'b00);
        observe(1, 576, 2400, 2400, -1, 6'd63, 1'b1, -1);
        check(first_dn, 2304, "R1 max ratio 2303 pump_dn edge");
        check(dn_a, 3, "R4 max ratio pump_dn width");
        check(up_a, 2, "R4 max ratio pump_up width");
        go_idle();
    endtask

    task automatic t_word_change();
        start_run(6'd0, 1'b0, 2'b00);
        observe(1, 544, 4500, 3000, 1000, 6'd2, 1'b1, -1);
        check(first_dn, 2177, "R9 mid-count change leaves current count");
        check(dn_a, 2, "R9 first comparison pump_dn width");
        check(up_b, 7, "R9 new ratio 2181 in second period pump_up");
        check(dn_b, 2, "R9 second period pump_dn width");
        go_idle();
    endtask

    task automatic t_drain();
        start_run(6'd1, 1'b0, 2'b00);
        observe(1, 544, 8000, 2300, -1, 6'd1, 1'b0, 2177);
        check(up_a, 4, "R7 pump_up completes after disable");
        check(dn_a, 2, "R7 pump_dn completes after disable");
        check(up_b + dn_b, 0, "R8 no requests after drain with ticks");
        go_idle();
    endtask

    task automatic t_restart();
        start_run(6'd0, 1'b0, 2'b00);
        observe(1, 544, 1200, 1200, -1, 6'd0, 1'b0, 1000);
        check(up_a + dn_a, 0, "R6 no requests before first terminal");
        start_run(6'd0, 1'b0, 2'b00);
        observe(1, 544, 2200, 2200, -1, 6'd0, 1'b0, -1);
        check(first_up, 2177, "R6 restart reloads reference counter");
        check(first_dn, 2177, "R6 restart reloads main counter");
        go_idle();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_idle();
        t_equal();
        t_lsb();
        t_bit_order();
        t_main_first();
        t_word_change();
        t_drain();
        t_restart();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule